// File: doc/BRIEF.md
# Pipelined Instruction Fetch Port

This block sits between a 32-bit processor core and a read-only AXI4-Lite link to program memory. The port keeps its own fetch address, which comes from a reset-vector parameter after reset. It issues one single-beat read per instruction word and moves on to the next word address without waiting for the core to ask. Several reads can be in flight at the same time, up to a parameter limit. Read data is always accepted. Each returned word goes into a small return buffer, and the core takes words from that buffer in the order the reads were issued.

The core changes the instruction stream with a redirect strobe and a target address. The target becomes the next fetch address. Words already in the return buffer are flushed. Reads still in flight for the old stream are counted, and their data is dropped when it arrives. A read request that the memory has not yet accepted is kept stable until it is accepted, and it is then treated as part of the old stream. Any nonzero read response turns into an access-fault flag that travels with its word. The write channels of the link are never used.

Top module: `instr_fetch_port`

## Requirements
- R1: The write side is idle at all times: m_awvalid, m_wvalid and m_bready are 0, and m_awaddr, m_wdata and m_wstrb are 0.
- R2: m_araddr always has bits [1:0] equal to 0. The two low bits of a redirect target are ignored, so a target t is fetched from t with bits [1:0] cleared.
- R3: Once m_arvalid is high, it stays high and m_araddr stays unchanged until a cycle in which m_arready is also high.
- R4: The number of accepted read addresses minus returned read beats never exceeds MAX_OUT. With slow memory and a stalled core, the count reaches MAX_OUT.
- R5: Each accepted read address is 4 more than the previous accepted address of the same stream. After a redirect, the first read of the new stream is at the aligned target.
- R6: m_rready is 1 in every cycle.
- R7: The core receives, in issue order, the m_rdata of every read in the current stream. A word is removed when insn_valid_o and insn_ready_i are both 1 and redir_valid_i is 0.
- R8: insn_fault_o is 1 exactly when the m_rresp returned with that word was nonzero (01, 10 or 11). It is 0 for response 00.
- R9: After a redirect cycle, the next word given to the core is the one fetched from the aligned target. Buffered words and data of reads issued before the redirect are never delivered. A pop in the redirect cycle itself has no effect.
- R10: While reset is asserted, m_arvalid and insn_valid_o are 0. The first read after reset is at RESET_VEC.
- R11: While insn_valid_o is 1, insn_ready_i is 0 and no redirect occurs, insn_valid_o, insn_word_o and insn_fault_o stay unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| redir_valid_i | input | 1 | Redirect strobe from the core |
| redir_pc_i | input | 32 | Redirect target address |
| insn_valid_o | output | 1 | A fetched word is available |
| insn_word_o | output | 32 | Instruction word at the head of the buffer |
| insn_fault_o | output | 1 | Access fault for the head word |
| insn_ready_i | input | 1 | Core takes the head word |
| m_awaddr | output | 32 | Write address, held at 0 |
| m_awprot | output | 3 | Write protection, held at 0 |
| m_awvalid | output | 1 | Write address valid, held at 0 |
| m_awready | input | 1 | Write address ready, ignored |
| m_wdata | output | 32 | Write data, held at 0 |
| m_wstrb | output | 4 | Write strobes, held at 0 |
| m_wvalid | output | 1 | Write data valid, held at 0 |
| m_wready | input | 1 | Write data ready, ignored |
| m_bresp | input | 2 | Write response, ignored |
| m_bvalid | input | 1 | Write response valid, ignored |
| m_bready | output | 1 | Write response ready, held at 0 |
| m_araddr | output | 32 | Word-aligned fetch address |
| m_arprot | output | 3 | Read protection, constant 3'b100 (instruction access) |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_rdata | input | 32 | Returned instruction word |
| m_rresp | input | 2 | Read response; a nonzero value means access fault |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready, constant 1 |

## Verification
The bench builds the port with MAX_OUT = 4 and RESET_VEC = 0x1000. A memory model with 1 to 20 cycles of latency then fills all four credits well within the run, and a core stall fills the four-entry return buffer. Together these reach both the issue limit and a full buffer. With the small limit, redirects in random cycles often land while reads are in flight, while the buffer holds old words, and while an unaccepted request is waiting. A directed case holds m_arready low across a redirect so that a stale pending request is always exercised.

// File: rtl/ifp_pkg.sv
package ifp_pkg;

  localparam int unsigned XLEN = 32;

  typedef logic [XLEN-1:0] word_t;

  // one returned instruction together with its access-fault flag
  typedef struct packed {
    logic  fault;
    word_t insn;
  } ret_beat_t;

  function automatic word_t word_align(input word_t a);
    return {a[XLEN-1:2], 2'b00};
  endfunction

endpackage

// File: rtl/ifp_ret_fifo.sv
module ifp_ret_fifo
  import ifp_pkg::*;
#(
  parameter  int unsigned DEPTH = 4,
  localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush_i,
  input  logic          push_i,
  input  ret_beat_t     beat_i,
  input  logic          pop_i,
  output ret_beat_t     beat_o,
  output logic [CW-1:0] count_o
);

  ret_beat_t         mem_q [DEPTH];
  logic [AW-1:0]     wr_ptr_q, wr_ptr_n;
  logic [AW-1:0]     rd_ptr_q, rd_ptr_n;
  logic [CW-1:0]     cnt_q, cnt_n;
  logic              wr_en, rd_en;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    wr_en    = push_i & ~flush_i;
    rd_en    = pop_i & (cnt_q != '0) & ~flush_i;
    wr_ptr_n = wr_ptr_q;
    rd_ptr_n = rd_ptr_q;
    cnt_n    = cnt_q;
    if (flush_i) begin
      wr_ptr_n = '0;
      rd_ptr_n = '0;
      cnt_n    = '0;
    end else begin
      if (wr_en) wr_ptr_n = bump(wr_ptr_q);
      if (rd_en) rd_ptr_n = bump(rd_ptr_q);
      cnt_n = cnt_q + CW'(wr_en) - CW'(rd_en);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_n;
      rd_ptr_q <= rd_ptr_n;
      cnt_q    <= cnt_n;
    end
  end

  // storage entries carry no reset; each has its own write enable
  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (wr_en && (wr_ptr_q == AW'(e))) mem_q[e] <= beat_i;
    end
  end

  assign beat_o  = mem_q[rd_ptr_q];
  assign count_o = cnt_q;

endmodule

// File: rtl/ifp_credit.sv
module ifp_credit #(
  parameter  int unsigned MAX_OUT = 4,
  localparam int unsigned CW      = $clog2(MAX_OUT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ar_hs_i,       // read address accepted this cycle
  input  logic          hs_stale_i,    // the accepted read belongs to an old stream
  input  logic          r_beat_i,      // read data returned this cycle
  input  logic          redir_i,
  output logic          drop_o,        // returned beat is to be discarded
  output logic [CW-1:0] out_next_o     // in-flight count after this cycle
);

  logic [CW-1:0] out_q, out_n;
  logic [CW-1:0] disc_q, disc_n;
  logic          dec_disc;

  always_comb begin
    dec_disc = r_beat_i & (disc_q != '0);
    out_n    = out_q + CW'(ar_hs_i) - CW'(r_beat_i);
    if (redir_i) begin
      // everything still in flight after this edge belongs to the old stream
      disc_n = out_n;
    end else begin
      disc_n = disc_q - CW'(dec_disc) + CW'(ar_hs_i & hs_stale_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      disc_q <= '0;
    end else begin
      out_q  <= out_n;
      disc_q <= disc_n;
    end
  end

  assign drop_o     = dec_disc;
  assign out_next_o = out_n;

endmodule

// File: rtl/ifp_req_gen.sv
module ifp_req_gen
  import ifp_pkg::*;
#(
  parameter word_t RESET_VEC = '0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  redir_i,
  input  word_t redir_pc_i,
  input  logic  room_i,        // credit allows a new request after this edge
  input  logic  arready_i,
  output logic  arvalid_o,
  output word_t araddr_o,
  output logic  hs_o,
  output logic  hs_stale_o
);

  logic  arv_q, arv_n;
  word_t addr_q, addr_n;
  word_t npc_q, npc_n;
  logic  stale_q, stale_n;
  logic  hs, launch;
  word_t base;

  always_comb begin
    hs     = arv_q & arready_i;
    launch = (~arv_q | hs) & room_i;
    base   = redir_i ? word_align(redir_pc_i) : npc_q;

    arv_n   = arv_q;
    addr_n  = addr_q;
    npc_n   = redir_i ? word_align(redir_pc_i) : npc_q;
    stale_n = stale_q;

    if (launch) begin
      arv_n   = 1'b1;
      addr_n  = base;
      npc_n   = base + word_t'(4);
      stale_n = 1'b0;
    end else if (hs) begin
      arv_n   = 1'b0;
      stale_n = 1'b0;
    end else if (redir_i && arv_q) begin
      // a request still waiting keeps its address but now belongs to the old stream
      stale_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arv_q   <= 1'b0;
      addr_q  <= '0;
      npc_q   <= word_align(RESET_VEC);
      stale_q <= 1'b0;
    end else begin
      arv_q   <= arv_n;
      addr_q  <= addr_n;
      npc_q   <= npc_n;
      stale_q <= stale_n;
    end
  end

  assign arvalid_o  = arv_q;
  assign araddr_o   = addr_q;
  assign hs_o       = hs;
  assign hs_stale_o = hs & stale_q;

endmodule

// File: rtl/instr_fetch_port.sv
module instr_fetch_port
  import ifp_pkg::*;
#(
  parameter int unsigned MAX_OUT   = 4,
  parameter logic [31:0] RESET_VEC = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        redir_valid_i,
  input  logic [31:0] redir_pc_i,
  output logic        insn_valid_o,
  output logic [31:0] insn_word_o,
  output logic        insn_fault_o,
  input  logic        insn_ready_i,
  output logic [31:0] m_awaddr,
  output logic [2:0]  m_awprot,
  output logic        m_awvalid,
  input  logic        m_awready,
  output logic [31:0] m_wdata,
  output logic [3:0]  m_wstrb,
  output logic        m_wvalid,
  input  logic        m_wready,
  input  logic [1:0]  m_bresp,
  input  logic        m_bvalid,
  output logic        m_bready,
  output logic [31:0] m_araddr,
  output logic [2:0]  m_arprot,
  output logic        m_arvalid,
  input  logic        m_arready,
  input  logic [31:0] m_rdata,
  input  logic [1:0]  m_rresp,
  input  logic        m_rvalid,
  output logic        m_rready
);

  localparam int unsigned CW = $clog2(MAX_OUT + 1);
  localparam int unsigned SW = CW + 2;

  logic          ar_hs, ar_hs_stale, room;
  logic          beat_drop, push, pop;
  logic [CW-1:0] out_next, fifo_cnt;
  logic [SW-1:0] fifo_next, committed;
  ret_beat_t     rx_beat, head_beat;
  logic          unused_wr_side;

  // write side of the link stays idle
  assign m_awaddr  = '0;
  assign m_awprot  = '0;
  assign m_awvalid = 1'b0;
  assign m_wdata   = '0;
  assign m_wstrb   = '0;
  assign m_wvalid  = 1'b0;
  assign m_bready  = 1'b0;
  assign unused_wr_side = ^{m_awready, m_wready, m_bresp, m_bvalid};

  // read side: instruction access, data always accepted
  assign m_arprot = 3'b100;
  assign m_rready = 1'b1;

  assign rx_beat = '{fault: (m_rresp != 2'b00), insn: m_rdata};
  assign push    = m_rvalid & ~beat_drop & ~redir_valid_i;
  assign pop     = insn_valid_o & insn_ready_i;

  // space accounting: every read in flight or waiting for acceptance owns a buffer slot
  always_comb begin
    if (redir_valid_i) fifo_next = '0;
    else               fifo_next = SW'(fifo_cnt) + SW'(push) - SW'(pop);
    committed = SW'(out_next) + fifo_next + SW'(m_arvalid & ~ar_hs);
    room      = committed < SW'(MAX_OUT);
  end

  ifp_req_gen #(
    .RESET_VEC (RESET_VEC)
  ) u_req (
    .clk        (clk),
    .rst_n      (rst_n),
    .redir_i    (redir_valid_i),
    .redir_pc_i (redir_pc_i),
    .room_i     (room),
    .arready_i  (m_arready),
    .arvalid_o  (m_arvalid),
    .araddr_o   (m_araddr),
    .hs_o       (ar_hs),
    .hs_stale_o (ar_hs_stale)
  );

  ifp_credit #(
    .MAX_OUT (MAX_OUT)
  ) u_credit (
    .clk        (clk),
    .rst_n      (rst_n),
    .ar_hs_i    (ar_hs),
    .hs_stale_i (ar_hs_stale),
    .r_beat_i   (m_rvalid),
    .redir_i    (redir_valid_i),
    .drop_o     (beat_drop),
    .out_next_o (out_next)
  );

  ifp_ret_fifo #(
    .DEPTH (MAX_OUT)
  ) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush_i (redir_valid_i),
    .push_i  (push),
    .beat_i  (rx_beat),
    .pop_i   (pop),
    .beat_o  (head_beat),
    .count_o (fifo_cnt)
  );

  assign insn_valid_o = (fifo_cnt != '0);
  assign insn_word_o  = head_beat.insn;
  assign insn_fault_o = head_beat.fault;

endmodule

// File: rtl/ifp_checker.sv
module ifp_checker #(
  parameter int unsigned MAX_OUT = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        m_awvalid,
  input logic        m_wvalid,
  input logic        m_bready,
  input logic        m_arvalid,
  input logic        m_arready,
  input logic [31:0] m_araddr,
  input logic        m_rvalid,
  input logic        m_rready,
  input logic        insn_valid_o,
  input logic        insn_ready_i,
  input logic [31:0] insn_word_o,
  input logic        insn_fault_o,
  input logic        redir_valid_i
);

  int infl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) infl_q <= 0;
    else        infl_q <= infl_q + int'(m_arvalid & m_arready) - int'(m_rvalid);
  end

  assert_write_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !m_awvalid && !m_wvalid && !m_bready);

  assert_addr_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    m_arvalid |-> (m_araddr[1:0] == 2'b00));

  assert_req_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (m_arvalid && !m_arready) |=> (m_arvalid && $stable(m_araddr)));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    infl_q <= int'(MAX_OUT));

  assert_rready_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    m_rready);

  assert_head_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid_o && !insn_ready_i && !redir_valid_i) |=>
      (insn_valid_o && $stable(insn_word_o) && $stable(insn_fault_o)));

endmodule

bind instr_fetch_port ifp_checker #(.MAX_OUT(MAX_OUT)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .m_awvalid     (m_awvalid),
  .m_wvalid      (m_wvalid),
  .m_bready      (m_bready),
  .m_arvalid     (m_arvalid),
  .m_arready     (m_arready),
  .m_araddr      (m_araddr),
  .m_rvalid      (m_rvalid),
  .m_rready      (m_rready),
  .insn_valid_o  (insn_valid_o),
  .insn_ready_i  (insn_ready_i),
  .insn_word_o   (insn_word_o),
  .insn_fault_o  (insn_fault_o),
  .redir_valid_i (redir_valid_i)
);

// File: tb/instr_fetch_port_tb_top.sv
`timescale 1ns/1ps
module instr_fetch_port_tb_top;

  localparam int unsigned MAX_OUT = 4;
  localparam logic [31:0] RVEC    = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        redir_valid_i;
  logic [31:0] redir_pc_i;
  logic        insn_valid_o;
  logic [31:0] insn_word_o;
  logic        insn_fault_o;
  logic        insn_ready_i;
  logic [31:0] m_awaddr;
  logic [2:0]  m_awprot;
  logic        m_awvalid;
  logic        m_awready;
  logic [31:0] m_wdata;
  logic [3:0]  m_wstrb;
  logic        m_wvalid;
  logic        m_wready;
  logic [1:0]  m_bresp;
  logic        m_bvalid;
  logic        m_bready;
  logic [31:0] m_araddr;
  logic [2:0]  m_arprot;
  logic        m_arvalid;
  logic        m_arready;
  logic [31:0] m_rdata;
  logic [1:0]  m_rresp;
  logic        m_rvalid;
  logic        m_rready;

  always #2.5 clk = ~clk;

  instr_fetch_port #(.MAX_OUT(MAX_OUT), .RESET_VEC(RVEC)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .redir_valid_i(redir_valid_i), .redir_pc_i(redir_pc_i),
    .insn_valid_o(insn_valid_o), .insn_word_o(insn_word_o),
    .insn_fault_o(insn_fault_o), .insn_ready_i(insn_ready_i),
    .m_awaddr(m_awaddr), .m_awprot(m_awprot), .m_awvalid(m_awvalid), .m_awready(m_awready),
    .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wvalid(m_wvalid), .m_wready(m_wready),
    .m_bresp(m_bresp), .m_bvalid(m_bvalid), .m_bready(m_bready),
    .m_araddr(m_araddr), .m_arprot(m_arprot), .m_arvalid(m_arvalid), .m_arready(m_arready),
    .m_rdata(m_rdata), .m_rresp(m_rresp), .m_rvalid(m_rvalid), .m_rready(m_rready)
  );

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  int pops   = 0;
  int max_seen = 0;
  bit done   = 1'b0;

  int ar_pct, r_pct, pop_pct, redir_pct, lat_lo, lat_hi;

  // memory model: accepted addresses with the cycle from which they may return
  logic [31:0] q_addr[$];
  int          q_due[$];

  logic [31:0] ar_exp;
  logic [31:0] exp_pc;
  bit          ar_stale  = 1'b0;
  bit          first_ar  = 1'b1;
  bit          prev_hold = 1'b0;
  logic [31:0] prev_addr = '0;
  bit          fresh     = 1'b0;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return a ^ 32'hC3A5_0F00;
  endfunction

  // fault encodings: word 5 of each 16 answers 10, word 11 answers 11, word 14 answers 01
  function automatic logic [1:0] mem_resp(input logic [31:0] a);
    case (a[5:2])
      4'd5:    return 2'b10;
      4'd11:   return 2'b11;
      4'd14:   return 2'b01;
      default: return 2'b00;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic step();
    logic [31:0] tgt;
    bit          hs, pop_ev;
    @(negedge clk);
    cyc++;
    // per-cycle checks of the outputs
    chk(!m_awvalid && !m_wvalid && !m_bready && m_awaddr == '0 && m_wdata == '0 && m_wstrb == '0,
        "R1 write side idle", {29'd0, m_awvalid, m_wvalid, m_bready}, 32'd0);
    chk(m_rready == 1'b1, "R6 rready high", {31'd0, m_rready}, 32'd1);
    if (m_arvalid)
      chk(m_araddr[1:0] == 2'b00, "R2 araddr aligned", m_araddr, {m_araddr[31:2], 2'b00});
    if (prev_hold)
      chk(m_arvalid && m_araddr == prev_addr, "R3 request held until accepted", m_araddr, prev_addr);

    // drive this cycle's inputs
    m_arready = ($urandom_range(0, 99) < ar_pct);
    m_rvalid  = 1'b0;
    m_rdata   = '0;
    m_rresp   = '0;
    if (q_addr.size() > 0 && q_due[0] <= cyc && $urandom_range(0, 99) < r_pct) begin
      m_rvalid = 1'b1;
      m_rdata  = mem_word(q_addr[0]);
      m_rresp  = mem_resp(q_addr[0]);
      void'(q_addr.pop_front());
      void'(q_due.pop_front());
    end
    tgt           = 32'h0004_0000 | ($urandom & 32'h0000_3FFF);
    redir_valid_i = ($urandom_range(0, 99) < redir_pct);
    redir_pc_i    = redir_valid_i ? tgt : 32'd0;
    insn_ready_i  = ($urandom_range(0, 99) < pop_pct);

    // events of the coming edge
    hs        = m_arvalid && m_arready;
    prev_hold = m_arvalid && !m_arready;
    prev_addr = m_araddr;
    if (hs) begin
      if (ar_stale) begin
        ar_stale = 1'b0;
      end else begin
        if (first_ar) chk(m_araddr == ar_exp, "R10 first read at reset vector", m_araddr, ar_exp);
        else          chk(m_araddr == ar_exp, "R5 sequential fetch address", m_araddr, ar_exp);
        first_ar = 1'b0;
        ar_exp   = ar_exp + 32'd4;
      end
      q_addr.push_back(m_araddr);
      q_due.push_back(cyc + $urandom_range(lat_lo, lat_hi));
    end
    chk(q_addr.size() <= MAX_OUT, "R4 outstanding within limit", q_addr.size(), MAX_OUT);
    if (q_addr.size() > max_seen) max_seen = q_addr.size();

    pop_ev = insn_valid_o && insn_ready_i && !redir_valid_i;
    if (pop_ev) begin
      if (fresh) chk(insn_word_o == mem_word(exp_pc), "R9 first word after redirect", insn_word_o, mem_word(exp_pc));
      else       chk(insn_word_o == mem_word(exp_pc), "R7 in-order word", insn_word_o, mem_word(exp_pc));
      chk(insn_fault_o == (mem_resp(exp_pc) != 2'b00), "R8 fault flag",
          {31'd0, insn_fault_o}, {31'd0, mem_resp(exp_pc) != 2'b00});
      exp_pc = exp_pc + 32'd4;
      fresh  = 1'b0;
      pops++;
    end
    if (redir_valid_i) begin
      exp_pc   = {tgt[31:2], 2'b00};
      ar_exp   = {tgt[31:2], 2'b00};
      ar_stale = m_arvalid && !m_arready;
      fresh    = 1'b1;
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic knobs(input int ar, input int r, input int pp, input int rd, input int lo, input int hi);
    ar_pct = ar; r_pct = r; pop_pct = pp; redir_pct = rd; lat_lo = lo; lat_hi = hi;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R7 run did not end actual=%0d expected<%0d", cyc, 190000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; redir_valid_i = 1'b0; redir_pc_i = '0; insn_ready_i = 1'b0;
    m_awready = 1'b0; m_wready = 1'b0; m_bresp = 2'b00; m_bvalid = 1'b0;
    m_arready = 1'b0; m_rdata = '0; m_rresp = '0; m_rvalid = 1'b0;
    ar_exp = RVEC; exp_pc = RVEC;
    knobs(100, 100, 100, 0, 1, 1);
    repeat (3) @(negedge clk);
    chk(!m_arvalid, "R10 no request in reset", {31'd0, m_arvalid}, 32'd0);
    chk(!insn_valid_o, "R10 no word in reset", {31'd0, insn_valid_o}, 32'd0);
    // ignored write-side inputs toggled during reset and after
    m_awready = 1'b1; m_wready = 1'b1; m_bvalid = 1'b1; m_bresp = 2'b11;
    rst_n = 1'b1;

    run(300);                          // streaming, fixed latency
    knobs(60, 70, 70, 0, 1, 6);  run(500);   // random handshakes
    knobs(100, 100, 0, 0, 8, 20); run(80);   // stalled core, slow memory: R4 limit
    knobs(100, 100, 100, 0, 1, 3); run(200);
    knobs(50, 80, 80, 5, 1, 10); run(1500);  // random redirects
    // directed: redirect while a request waits unaccepted
    knobs(0, 100, 100, 0, 1, 3); run(4);
    redir_pct = 100; run(1);
    redir_pct = 0;   run(3);
    ar_pct = 100;    run(200);
    // directed: redirect with a full buffer
    knobs(100, 100, 0, 0, 2, 4); run(40);
    redir_pct = 100; run(1);
    knobs(100, 100, 100, 0, 1, 4); run(200);

    chk(max_seen == MAX_OUT, "R4 limit reached", max_seen, MAX_OUT);
    chk(pops > 400, "R7 words delivered", pops, 401);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule